// File: doc/BRIEF.md
# Battery Charge Sequencer

This block is the digital controller of a single-cell lithium-ion or four-cell nickel-metal-hydride charger. The analog front end supplies comparator flags (battery over the preconditioning threshold, battery at regulation voltage, battery under the restart threshold, nickel pack at its top limit) and a digitized charge current in milliamps. The sequencer turns these into a regulation-loop command (current loop or voltage loop), a target current, a pass-device enable, a regulation-voltage select and two status lamp drives.

A lithium cycle runs a low-current preconditioning phase, then fast charge at the programmed current, then constant-voltage taper. The cycle ends when the measured current stays below a selectable fraction of the programmed current. The block then waits in maintenance until the cell sags below the restart threshold. A backup timer runs only during fast charge. When it expires, the block either latches a fault with both lamps lit or, if the timer guard input is low, goes to maintenance. A nickel cycle is voltage-loop only and has no timer and no end-of-charge detection. Separate inputs select a test-supply (LDO) mode and a disabled mode.

Top module: `chg_seq_top`

## Requirements
- R1: Synchronous reset puts the block in state OFF. The state codes on `state_o` are OFF=0, PREQ=1, CC=2, CV=3, MAINT=4, FAULT=5, LDO=6, DIS=7. In OFF, every output is low and `i_target` is 0.
- R2: With `adapt_ok`=1, `enable`=1, `ldo_sel`=0 and `nimh_sel`=0, the block leaves OFF for PREQ. PREQ drives the current loop (`reg_mode`=0), sets `chg_on`=1 and `i_target`=PQ_MA (50). On the first cycle after the adaptor is attached, the red lamp is on and the green lamp is off.
- R3: In PREQ, `cmp_pq_ok`=1 moves the block to CC, with `i_target`=500+50*`iset_code`. Codes above 9 are treated as 9 (950).
- R4: In CC, `cmp_vreg`=1 moves the block to CV, which drives the voltage loop (`reg_mode`=1) at the same target.
- R5: In lithium CV, end of charge occurs when `ichg_ma` is strictly below floor(C*k/20) for EOC_FILT (4) consecutive clocks. Here C is the target and k is 2, 3 or 4 for `eoc_sel` 1, 2 or 3 (0 behaves as 1). A shorter dip has no effect. End of charge leads to MAINT: `chg_on`=0, green on, red off.
- R6: In MAINT, `cmp_restart`=1 starts a new cycle in PREQ. Until the adaptor is lost, charging after a maintenance phase shows green on and red off.
- R7: When the safety timer (PRESC_DIV*TMR_TICKS clocks in CC) expires in CC, the block goes to FAULT (both lamps on, `chg_on`=0) if `tmr_guard`=1, and to MAINT if `tmr_guard`=0.
- R8: The timer counts only in CC and clears when CC is left. A block that reaches CV before expiry never faults, however long it stays in CV.
- R9: With `nimh_sel`=1 at cycle start, the block goes straight to CV (voltage loop, red on, green off). `chg_on` equals the inverse of `cmp_nimh_top`. Low current and elapsed time never end the state.
- R10: `enable`=0 with a valid adaptor forces DIS from any state, including FAULT: green on, red off, `chg_on`=0. FAULT is otherwise held. Raising `enable` starts a new cycle.
- R11: `ldo_sel`=1 forces LDO: `chg_on`=1, `reg_mode`=1, `i_target`=LDO_MA (1200), both lamps off.
- R12: `adapt_ok`=0 forces OFF from any state and clears the after-maintenance lamp flag.
- R13: Chemistry and `vsel_hi` are captured when a cycle starts (`vsel_hi` is also captured on restart), and `vreg_hi` shows the captured value. Changes during a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adapt_ok | input | 1 | Adaptor within under/over-voltage and headroom limits |
| enable | input | 1 | Charger/LDO enable |
| ldo_sel | input | 1 | High selects test-supply mode (no battery ID) |
| tmr_guard | input | 1 | High: timer expiry faults; low: expiry goes to maintenance |
| nimh_sel | input | 1 | Nickel chemistry select |
| vsel_hi | input | 1 | Higher regulation voltage select |
| cmp_pq_ok | input | 1 | Battery above preconditioning threshold |
| cmp_vreg | input | 1 | Battery at regulation voltage |
| cmp_restart | input | 1 | Battery below restart threshold |
| cmp_nimh_top | input | 1 | Nickel pack at top limit |
| ichg_ma | input | I_W | Measured charge current, mA |
| iset_code | input | 4 | Fast-charge current code |
| eoc_sel | input | 2 | End-of-charge fraction select |
| state_o | output | 3 | Current state code |
| chg_on | output | 1 | Pass device enable |
| reg_mode | output | 1 | 0 current loop, 1 voltage loop |
| i_target | output | I_W | Target current, mA |
| led_red | output | 1 | Red lamp on |
| led_green | output | 1 | Green lamp on |
| vreg_hi | output | 1 | Captured regulation-voltage select |

## Verification
The assertions take the comparator flags and the adaptor input as already synchronous to `clk` and free of glitches. They assume nothing about how the flags relate to each other, so any combination is legal. The stimulus changes inputs only at falling edges and holds each setting for several clocks. It drives physically odd flag combinations (for example restart and regulation flags together) only where a requirement says which one wins. The timer is shortened through parameters so that expiry and non-expiry windows fit into short runs.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PREQ  = 3'd1,
    ST_CC    = 3'd2,
    ST_CV    = 3'd3,
    ST_MAINT = 3'd4,
    ST_FAULT = 3'd5,
    ST_LDO   = 3'd6,
    ST_DIS   = 3'd7
  } chg_state_e;
endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int PRESC_DIV = 1000,
  parameter int TMR_TICKS = 20160
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TMR_TICKS + 1);
  logic tick;
  logic [TW-1:0] tcnt;

  chg_tick_gen #(.DIV(PRESC_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  assign expired = (tcnt == TW'(TMR_TICKS));

  always_ff @(posedge clk) begin
    if (rst || !run) tcnt <= '0;
    else if (tick && !expired) tcnt <= tcnt + 1'b1;
  end
endmodule

// File: rtl/chg_eoc_detect.sv
module chg_eoc_detect #(
  parameter int I_W      = 11,
  parameter int BASE_MA  = 500,
  parameter int STEP_MA  = 50,
  parameter int MAX_CODE = 9,
  parameter int EOC_FILT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic [3:0]     iset_code,
  input  logic [1:0]     eoc_sel,
  input  logic [I_W-1:0] ichg_ma,
  output logic [I_W-1:0] cur_ma,
  output logic           eoc_hit
);
  localparam int FW = $clog2(EOC_FILT + 1);
  localparam int PW = I_W + 3;
  localparam logic [3:0] MAXC = 4'(MAX_CODE);

  logic [3:0]    code_eff;
  logic [PW-1:0] num;
  logic [PW-1:0] prod;
  logic [PW-1:0] thresh;
  logic          below;
  logic [FW-1:0] cnt;

  always_comb begin
    code_eff = (iset_code > MAXC) ? MAXC : iset_code;
    cur_ma   = I_W'(BASE_MA) + I_W'(STEP_MA) * I_W'(code_eff);
    case (eoc_sel)
      2'd2:    num = PW'(3);
      2'd3:    num = PW'(4);
      default: num = PW'(2);
    endcase
    prod   = PW'(cur_ma) * num;
    thresh = prod / PW'(20);
    below  = PW'(ichg_ma) < thresh;
  end

  always_ff @(posedge clk) begin
    if (rst || !arm || !below) cnt <= '0;
    else if (cnt < FW'(EOC_FILT - 1)) cnt <= cnt + 1'b1;
  end

  assign eoc_hit = arm && below && (cnt >= FW'(EOC_FILT - 1));
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adapt_ok,
  input  logic       enable,
  input  logic       ldo_sel,
  input  logic       tmr_guard,
  input  logic       nimh_sel,
  input  logic       vsel_hi,
  input  logic       cmp_pq_ok,
  input  logic       cmp_vreg,
  input  logic       cmp_restart,
  input  logic       tmr_expired,
  input  logic       eoc_hit,
  output chg_state_e st_q,
  output logic       chem_q,
  output logic       vh_q,
  output logic       rech_q
);
  chg_state_e nxt;
  logic start, restart;

  always_comb begin
    nxt     = st_q;
    start   = 1'b0;
    restart = 1'b0;
    if (!adapt_ok)     nxt = ST_OFF;
    else if (!enable)  nxt = ST_DIS;
    else if (ldo_sel)  nxt = ST_LDO;
    else begin
      case (st_q)
        ST_OFF, ST_DIS, ST_LDO: begin
          start = 1'b1;
          nxt   = nimh_sel ? ST_CV : ST_PREQ;
        end
        ST_PREQ: if (cmp_pq_ok) nxt = ST_CC;
        ST_CC: begin
          if (tmr_expired)   nxt = tmr_guard ? ST_FAULT : ST_MAINT;
          else if (cmp_vreg) nxt = ST_CV;
        end
        ST_CV:    if (!chem_q && eoc_hit) nxt = ST_MAINT;
        ST_MAINT: if (cmp_restart) begin
          nxt     = ST_PREQ;
          restart = 1'b1;
        end
        default: nxt = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OFF;
      chem_q <= 1'b0;
      vh_q   <= 1'b0;
      rech_q <= 1'b0;
    end else begin
      st_q <= nxt;
      if (start) chem_q <= nimh_sel;
      if (start || restart) vh_q <= vsel_hi;
      if (!adapt_ok) rech_q <= 1'b0;
      else if (nxt == ST_MAINT) rech_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int PRESC_DIV = 1000,
  parameter int TMR_TICKS = 20160,
  parameter int EOC_FILT  = 4,
  parameter int I_W       = 11,
  parameter int PQ_MA     = 50,
  parameter int BASE_MA   = 500,
  parameter int STEP_MA   = 50,
  parameter int MAX_CODE  = 9,
  parameter int LDO_MA    = 1200
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adapt_ok,
  input  logic           enable,
  input  logic           ldo_sel,
  input  logic           tmr_guard,
  input  logic           nimh_sel,
  input  logic           vsel_hi,
  input  logic           cmp_pq_ok,
  input  logic           cmp_vreg,
  input  logic           cmp_restart,
  input  logic           cmp_nimh_top,
  input  logic [I_W-1:0] ichg_ma,
  input  logic [3:0]     iset_code,
  input  logic [1:0]     eoc_sel,
  output logic [2:0]     state_o,
  output logic           chg_on,
  output logic           reg_mode,
  output logic [I_W-1:0] i_target,
  output logic           led_red,
  output logic           led_green,
  output logic           vreg_hi
);
  chg_state_e     st;
  logic           chem, vh, rech, expired, eoc_hit;
  logic [I_W-1:0] cur_ma;

  chg_safety_timer #(.PRESC_DIV(PRESC_DIV), .TMR_TICKS(TMR_TICKS)) u_timer (
    .clk(clk), .rst(rst), .run(st == ST_CC), .expired(expired)
  );

  chg_eoc_detect #(
    .I_W(I_W), .BASE_MA(BASE_MA), .STEP_MA(STEP_MA),
    .MAX_CODE(MAX_CODE), .EOC_FILT(EOC_FILT)
  ) u_eoc (
    .clk(clk), .rst(rst), .arm((st == ST_CV) && !chem),
    .iset_code(iset_code), .eoc_sel(eoc_sel), .ichg_ma(ichg_ma),
    .cur_ma(cur_ma), .eoc_hit(eoc_hit)
  );

  chg_fsm u_fsm (
    .clk(clk), .rst(rst), .adapt_ok(adapt_ok), .enable(enable),
    .ldo_sel(ldo_sel), .tmr_guard(tmr_guard), .nimh_sel(nimh_sel),
    .vsel_hi(vsel_hi), .cmp_pq_ok(cmp_pq_ok), .cmp_vreg(cmp_vreg),
    .cmp_restart(cmp_restart), .tmr_expired(expired), .eoc_hit(eoc_hit),
    .st_q(st), .chem_q(chem), .vh_q(vh), .rech_q(rech)
  );

  assign state_o = st;

  logic           on_d, mode_d, red_d, grn_d;
  logic [I_W-1:0] tgt_d;

  always_comb begin
    on_d = 1'b0; mode_d = 1'b0; red_d = 1'b0; grn_d = 1'b0; tgt_d = '0;
    case (st)
      ST_PREQ: begin
        on_d = 1'b1; tgt_d = I_W'(PQ_MA);
        red_d = !rech; grn_d = rech;
      end
      ST_CC: begin
        on_d = 1'b1; tgt_d = cur_ma;
        red_d = !rech; grn_d = rech;
      end
      ST_CV: begin
        mode_d = 1'b1; tgt_d = cur_ma;
        if (chem) begin
          on_d = !cmp_nimh_top; red_d = 1'b1;
        end else begin
          on_d = 1'b1; red_d = !rech; grn_d = rech;
        end
      end
      ST_MAINT: grn_d = 1'b1;
      ST_FAULT: begin red_d = 1'b1; grn_d = 1'b1; end
      ST_LDO: begin
        on_d = 1'b1; mode_d = 1'b1; tgt_d = I_W'(LDO_MA);
      end
      ST_DIS: grn_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_on <= 1'b0; reg_mode <= 1'b0; i_target <= '0;
      led_red <= 1'b0; led_green <= 1'b0; vreg_hi <= 1'b0;
    end else begin
      chg_on <= on_d; reg_mode <= mode_d; i_target <= tgt_d;
      led_red <= red_d; led_green <= grn_d; vreg_hi <= vh;
    end
  end
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
  parameter int I_W    = 11,
  parameter int PQ_MA  = 50,
  parameter int LDO_MA = 1200
) (
  input logic           clk,
  input logic           rst,
  input logic           adapt_ok,
  input logic           enable,
  input logic [2:0]     state_o,
  input logic           chg_on,
  input logic           reg_mode,
  input logic [I_W-1:0] i_target,
  input logic           led_red,
  input logic           led_green
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (state_o == 3'd0 && !chg_on && !led_red && !led_green && i_target == '0));

  a_r12_adaptor_loss: assert property (@(posedge clk) disable iff (rst)
    !adapt_ok |=> state_o == 3'd0);

  a_r10_disable_wins: assert property (@(posedge clk) disable iff (rst)
    (adapt_ok && !enable) |=> state_o == 3'd7);

  a_r10_fault_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5 && adapt_ok && enable) |=> state_o == 3'd5);

  a_r7_fault_lamps: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd5 |=> (led_red && led_green && !chg_on));

  a_r2_preq_drive: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd1 |=> (i_target == I_W'(PQ_MA) && !reg_mode && chg_on));

  a_r4_cv_voltage_loop: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd3 |=> reg_mode);

  a_r5_maint_idle: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd4 |=> (!chg_on && led_green && !led_red));

  a_r11_ldo_drive: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd6 |=> (chg_on && reg_mode && i_target == I_W'(LDO_MA)
                         && !led_red && !led_green));
endmodule

bind chg_seq_top chg_seq_chk #(.I_W(I_W), .PQ_MA(PQ_MA), .LDO_MA(LDO_MA)) u_chk (
  .clk(clk), .rst(rst), .adapt_ok(adapt_ok), .enable(enable),
  .state_o(state_o), .chg_on(chg_on), .reg_mode(reg_mode),
  .i_target(i_target), .led_red(led_red), .led_green(led_green)
);

// File: tb/chg_seq_top_test.sv
`timescale 1ns/1ps
module chg_seq_top_test;
  localparam int DIV = 4;
  localparam int TCK = 25;
  localparam int VW = 45;
  localparam int NV = 14;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adapt_ok = 0, enable = 0, ldo_sel = 0, tmr_guard = 1, nimh_sel = 0, vsel_hi = 0;
  logic cmp_pq_ok = 0, cmp_vreg = 0, cmp_restart = 0, cmp_nimh_top = 0;
  logic [10:0] ichg_ma = '0;
  logic [3:0]  iset_code = '0;
  logic [1:0]  eoc_sel = '0;
  logic [2:0]  state_o;
  logic        chg_on, reg_mode, led_red, led_green, vreg_hi;
  logic [10:0] i_target;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chg_seq_top #(.PRESC_DIV(DIV), .TMR_TICKS(TCK)) uut (
    .clk(clk), .rst(rst), .adapt_ok(adapt_ok), .enable(enable), .ldo_sel(ldo_sel),
    .tmr_guard(tmr_guard), .nimh_sel(nimh_sel), .vsel_hi(vsel_hi),
    .cmp_pq_ok(cmp_pq_ok), .cmp_vreg(cmp_vreg), .cmp_restart(cmp_restart),
    .cmp_nimh_top(cmp_nimh_top), .ichg_ma(ichg_ma), .iset_code(iset_code),
    .eoc_sel(eoc_sel), .state_o(state_o), .chg_on(chg_on), .reg_mode(reg_mode),
    .i_target(i_target), .led_red(led_red), .led_green(led_green), .vreg_hi(vreg_hi)
  );

  function automatic logic [VW-1:0] mkv(
    bit a, bit e, bit l, bit b, bit n, bit h, bit pq, bit rg, bit rs, bit mx,
    int ich, int code, int es, int st, bit r, bit g, bit c, bit m, int tgt);
    return {a, e, l, b, n, h, pq, rg, rs, mx, 11'(ich), 4'(code), 2'(es),
            3'(st), r, g, c, m, 11'(tgt)};
  endfunction

  // fields: adapt en ldo guard nimh vhi pq vreg restart top | ichg code eoc | state red grn on mode tgt
  localparam logic [VW-1:0] TBL [NV] = '{
    mkv(0,0,0,1,0,0, 0,0,0,0,   0,4,3, 0, 0,0,0,0,    0),
    mkv(1,1,0,1,0,0, 0,0,0,0, 300,4,3, 1, 1,0,1,0,   50),
    mkv(1,1,0,1,0,0, 1,0,0,0, 300,4,3, 2, 1,0,1,0,  700),
    mkv(1,1,0,1,0,0, 1,1,0,0, 300,4,3, 3, 1,0,1,1,  700),
    mkv(1,1,0,1,0,0, 1,1,0,0, 141,4,3, 3, 1,0,1,1,  700),
    mkv(1,1,0,1,0,0, 1,1,0,0, 139,4,3, 4, 0,1,0,0,    0),
    mkv(1,1,0,1,0,0, 0,0,1,0, 139,4,3, 1, 0,1,1,0,   50),
    mkv(1,1,0,1,0,0, 1,0,0,0, 300,4,3, 2, 0,1,1,0,  700),
    mkv(1,1,1,1,0,0, 1,0,0,0, 300,4,3, 6, 0,0,1,1, 1200),
    mkv(1,0,0,1,0,0, 0,0,0,0, 300,4,3, 7, 0,1,0,0,    0),
    mkv(1,1,0,1,1,0, 0,0,0,0,  10,4,3, 3, 1,0,1,1,  700),
    mkv(1,1,0,1,1,0, 0,0,0,1,  10,4,3, 3, 1,0,0,1,  700),
    mkv(0,1,0,1,1,0, 0,0,0,1,  10,4,3, 0, 0,0,0,0,    0),
    mkv(1,1,0,1,0,0, 0,0,0,0,  10,4,3, 1, 1,0,1,0,   50)
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R12"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4, 5: return "R5"; 6, 7: return "R6"; 8: return "R11"; 9: return "R10";
      10, 11: return "R9"; 12: return "R12"; default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_adaptor();
    adapt_ok = 0;
    settle(3);
  endtask

  initial begin
    settle(3);
    chk("R1 reset state", 32'(state_o), 0);
    chk("R1 reset outputs", {chg_on, reg_mode, led_red, led_green, vreg_hi, i_target}, 0);
    rst = 0;
    settle(1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      {adapt_ok, enable, ldo_sel, tmr_guard, nimh_sel, vsel_hi,
       cmp_pq_ok, cmp_vreg, cmp_restart, cmp_nimh_top} = v[44:35];
      ichg_ma = v[34:24]; iset_code = v[23:20]; eoc_sel = v[19:18];
      settle(HOLD);
      chk(vreq(i), 32'({state_o, led_red, led_green, chg_on, reg_mode, i_target}), 32'(v[17:0]));
    end

    // R3 clamp and low end of the code range (currently in PREQ)
    iset_code = 4'd15; cmp_pq_ok = 1;
    settle(4);
    chk("R3 clamp state", 32'(state_o), 2);
    chk("R3 code 15 clamps to 950", 32'(i_target), 950);
    iset_code = 4'd0;
    settle(3);
    chk("R3 code 0 gives 500", 32'(i_target), 500);

    // R13 capture, R8 before expiry, R7 fault, R10 hold/exit
    drop_adaptor();
    vsel_hi = 1; cmp_pq_ok = 0; adapt_ok = 1;
    settle(4);
    chk("R13 vreg captured", 32'(vreg_hi), 1);
    vsel_hi = 0;
    settle(3);
    chk("R13 mid-cycle change ignored", 32'(vreg_hi), 1);
    cmp_pq_ok = 1;
    settle(80);
    chk("R8 still in CC before expiry", 32'(state_o), 2);
    settle(30);
    chk("R7 fault state", 32'(state_o), 5);
    chk("R7 fault lamps and pass off", {led_red, led_green, chg_on}, 3'b110);
    cmp_vreg = 1;
    settle(5);
    chk("R10 fault held", 32'(state_o), 5);
    enable = 0;
    settle(3);
    chk("R10 disable leaves fault", 32'({state_o, led_red, led_green, chg_on}), {3'd7, 3'b010});
    cmp_vreg = 0; enable = 1;
    settle(3);
    chk("R10 re-enable restarts cycle", 32'(state_o), 2);

    // R7 with timer guard low
    drop_adaptor();
    tmr_guard = 0; adapt_ok = 1;
    settle(120);
    chk("R7 bypass goes to maintenance", 32'({state_o, led_red, led_green}), {3'd4, 2'b01});

    // R8 long CV stay with no fault; R5 filter, boundaries; R13 chemistry latch
    drop_adaptor();
    tmr_guard = 1; iset_code = 0; eoc_sel = 0; ichg_ma = 900; adapt_ok = 1;
    settle(60);
    cmp_vreg = 1;
    settle(200);
    chk("R8 no fault after CC left", 32'(state_o), 3);
    ichg_ma = 10;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ichg_ma = 900;
    settle(5);
    chk("R5 short dip ignored", 32'(state_o), 3);
    nimh_sel = 1; ichg_ma = 50;
    settle(8);
    chk("R5 at threshold 50 stays", 32'(state_o), 3);
    ichg_ma = 49;
    settle(8);
    chk("R5 R13 below 50 ends lithium cycle", 32'(state_o), 4);

    drop_adaptor();
    nimh_sel = 0; iset_code = 9; eoc_sel = 2; ichg_ma = 142; adapt_ok = 1;
    settle(10);
    chk("R5 0.15C of 950 at 142 stays", 32'(state_o), 3);
    ichg_ma = 141;
    settle(8);
    chk("R5 0.15C of 950 at 141 ends", 32'(state_o), 4);

    // R9 nickel: no timer, no end of charge
    drop_adaptor();
    nimh_sel = 1; cmp_vreg = 0; cmp_pq_ok = 0; ichg_ma = 0; adapt_ok = 1;
    settle(150);
    chk("R9 nickel holds in CV", 32'({state_o, led_red, led_green, chg_on, reg_mode}), {3'd3, 4'b1011});

    // R12 from nickel CV
    drop_adaptor();
    chk("R12 adaptor loss", 32'({state_o, chg_on, led_red, led_green, i_target}), 0);

    // R1 reset during fast charge
    nimh_sel = 0; cmp_pq_ok = 1; adapt_ok = 1;
    settle(4);
    rst = 1;
    settle(2);
    chk("R1 reset mid-charge", 32'({state_o, chg_on, reg_mode, led_red, led_green, i_target}), 0);
    rst = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule